// File: doc/BRIEF.md
# Nibble Adder with Hexadecimal Display

A purely combinational block that takes one 8-bit switch vector carrying two unsigned 4-bit operands, adds them in a ripple-carry adder built from full-adder stages, and drives four active-low seven-segment digits. Two digits echo the operands. The other two show the 5-bit sum: the low nibble on one digit and the carry on the other.

A single hex-to-segment decoder is written once and instantiated four times, one per digit. The carry digit is fed the carry bit zero-extended to four bits, so it only ever shows 0 or 1. The block has no clock and no state, so every output follows its inputs after settling.

Top module: `nibble_hex_adder`

## Requirements
- R1: Operand A is `sw_i[3:0]`, and `dig0_o` shows the hex glyph of A.
- R2: Operand B is `sw_i[7:4]`, and `dig1_o` shows the hex glyph of B.
- R3: The sum is the 5-bit value A+B, with carry-in 0 and the carry out as bit 4. The largest result, 15+15, is 5'b11110, and no input pattern overflows 5 bits.
- R4: `dig2_o` shows the glyph of sum bits [3:0].
- R5: `dig3_o` shows the glyph of the zero-extended sum bit 4, so it only ever shows glyph 0 or glyph 1.
- R6: Segments are active low (1 = dark). Bit i of a digit bus drives segment i, and bit 6 is the middle bar. The glyphs for digits 0..9 are 0=7'b1000000, 1=7'b1111001, 2=7'b0100100, 3=7'b0110000, 4=7'b0011001, 5=7'b0010010, 6=7'b0000010, 7=7'b1111000, 8=7'b0000000, 9=7'b0010000.
- R7: The glyphs for A..F use forms that are readable on seven segments, with lowercase b and d: A=7'b0001000, b=7'b0000011, C=7'b1000110, d=7'b0100001, E=7'b0000110, F=7'b0001110.
- R8: With `sw_i` = 8'h00, all four digits show glyph 0.
- R9: The outputs depend only on the present `sw_i`, with no clock and no memory. A changed input is reflected on all digits as soon as the logic settles, whatever value came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw_i | input | 8 | Operand B in [7:4], operand A in [3:0] |
| dig0_o | output | 7 | Active-low segments, operand A |
| dig1_o | output | 7 | Active-low segments, operand B |
| dig2_o | output | 7 | Active-low segments, low nibble of the sum |
| dig3_o | output | 7 | Active-low segments, carry of the sum |

## Verification
The embedded assertions check on every input change that the ripple chain agrees with arithmetic addition, that the carry digit only ever shows glyph 0 or glyph 1, that only the value 8 lights all segments, and that a zero B operand makes the sum digit repeat the A digit. The exact glyph for each of the sixteen values, the operand-to-digit routing, and the reaction to arbitrary input sequences are shown only by the bench. The bench runs directed cases and sweeps all 256 input pairs against glyphs it derives from the requirements.

// File: rtl/nibble_hex_pkg.sv
package nibble_hex_pkg;
  localparam int unsigned SEG_W = 7;
  localparam int unsigned HEX_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_GLYPH_0 = 7'b1000000;
  localparam seg_t SEG_GLYPH_1 = 7'b1111001;
  localparam seg_t SEG_ALL_ON  = '0;
endpackage

// File: rtl/full_adder.sv
module full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (p & c_i);
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int unsigned RES_W = WIDTH + 1;

  logic [WIDTH:0] carry;
  assign carry[0] = 1'b0;  // no carry-in

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    full_adder u_fa (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (carry[i]),
      .s_o (sum_o[i]),
      .c_o (carry[i+1])
    );
  end

  assign carry_o = carry[WIDTH];

  // R3: chain must agree with arithmetic addition
  always_comb begin
    if (!$isunknown({a_i, b_i, sum_o, carry_o}))
      p_no_overflow_r3: assert ({carry_o, sum_o} == RES_W'(a_i) + RES_W'(b_i))
        else $error("ripple chain result mismatch");
  end
endmodule

// File: rtl/hex_seg_decoder.sv
module hex_seg_decoder
  import nibble_hex_pkg::*;
(
  input  logic [HEX_W-1:0] val_i,
  output seg_t             seg_o
);
  always_comb begin
    unique case (val_i)
      4'h0:    seg_o = 7'b1000000;
      4'h1:    seg_o = 7'b1111001;
      4'h2:    seg_o = 7'b0100100;
      4'h3:    seg_o = 7'b0110000;
      4'h4:    seg_o = 7'b0011001;
      4'h5:    seg_o = 7'b0010010;
      4'h6:    seg_o = 7'b0000010;
      4'h7:    seg_o = 7'b1111000;
      4'h8:    seg_o = 7'b0000000;
      4'h9:    seg_o = 7'b0010000;
      4'hA:    seg_o = 7'b0001000;
      4'hB:    seg_o = 7'b0000011;
      4'hC:    seg_o = 7'b1000110;
      4'hD:    seg_o = 7'b0100001;
      4'hE:    seg_o = 7'b0000110;
      default: seg_o = 7'b0001110;
    endcase
  end

  // R6: only 8 lights every segment; 1 lights exactly two
  always_comb begin
    if (!$isunknown({val_i, seg_o})) begin
      p_all_on_only_eight_r6: assert ((seg_o == SEG_ALL_ON) == (val_i == 4'h8))
        else $error("all-on glyph on wrong value");
      p_one_two_segments_r6: assert ((val_i != 4'h1) || ($countones(~seg_o) == 2))
        else $error("glyph 1 lit count wrong");
    end
  end
endmodule

// File: rtl/nibble_hex_adder.sv
module nibble_hex_adder
  import nibble_hex_pkg::*;
(
  input  logic [7:0]       sw_i,
  output logic [SEG_W-1:0] dig0_o,
  output logic [SEG_W-1:0] dig1_o,
  output logic [SEG_W-1:0] dig2_o,
  output logic [SEG_W-1:0] dig3_o
);
  localparam int unsigned NUM_DIGITS = 4;

  logic [HEX_W-1:0] op_a, op_b, sum_lo;
  logic             sum_hi;
  logic [HEX_W-1:0] digit_val [NUM_DIGITS];
  seg_t             digit_seg [NUM_DIGITS];

  assign op_a = sw_i[HEX_W-1:0];
  assign op_b = sw_i[2*HEX_W-1:HEX_W];

  ripple_adder #(.WIDTH(HEX_W)) u_add (
    .a_i     (op_a),
    .b_i     (op_b),
    .sum_o   (sum_lo),
    .carry_o (sum_hi)
  );

  assign digit_val[0] = op_a;
  assign digit_val[1] = op_b;
  assign digit_val[2] = sum_lo;
  assign digit_val[3] = {{(HEX_W-1){1'b0}}, sum_hi};

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    hex_seg_decoder u_dec (
      .val_i (digit_val[d]),
      .seg_o (digit_seg[d])
    );
  end

  assign dig0_o = digit_seg[0];
  assign dig1_o = digit_seg[1];
  assign dig2_o = digit_seg[2];
  assign dig3_o = digit_seg[3];

  always_comb begin
    if (!$isunknown({sw_i, dig0_o, dig2_o, dig3_o})) begin
      // R5: carry digit shows only 0 or 1
      p_carry_glyph_r5: assert ((dig3_o == SEG_GLYPH_0) || (dig3_o == SEG_GLYPH_1))
        else $error("carry digit glyph invalid");
      // R4: adding zero B repeats A on the sum digit
      p_sum_tracks_a_r4: assert ((sw_i[7:4] != 4'h0) || (dig2_o == dig0_o))
        else $error("sum digit differs from A with B zero");
      // R8: zero input shows 0 on the carry digit
      p_zero_carry_r8: assert ((sw_i != 8'h00) || (dig3_o == SEG_GLYPH_0))
        else $error("carry digit not 0 for zero input");
    end
  end
endmodule

// File: tb/tb_nibble_hex_adder.sv
module tb_nibble_hex_adder;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 5000;

  logic       clk = 1'b0;
  logic [7:0] sw;
  logic [6:0] d0, d1, d2, d3;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_hex_adder dut (
    .sw_i   (sw),
    .dig0_o (d0),
    .dig1_o (d1),
    .dig2_o (d2),
    .dig3_o (d3)
  );

  // glyph list taken from R6/R7
  function automatic logic [6:0] glyph(input int v);
    logic [6:0] t [16];
    t = '{7'b1000000, 7'b1111001, 7'b0100100, 7'b0110000,
          7'b0011001, 7'b0010010, 7'b0000010, 7'b1111000,
          7'b0000000, 7'b0010000, 7'b0001000, 7'b0000011,
          7'b1000110, 7'b0100001, 7'b0000110, 7'b0001110};
    return t[v & 15];
  endfunction

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s sw=%02h got=%07b exp=%07b", req, sw, got, exp);
    end
  endtask

  // apply on negedge, sample mid-low phase
  task automatic apply_and_check(input int a, input int b, input string tag);
    int s;
    @(negedge clk);
    sw = 8'((b << 4) | a);
    #1;
    s = a + b;
    check({tag, " R1 dig0"}, d0, glyph(a));
    check({tag, " R2 dig1"}, d1, glyph(b));
    check({tag, " R4 dig2"}, d2, glyph(s % 16));
    check({tag, " R5 dig3"}, d3, glyph(s / 16));
  endtask

  task automatic t_zero_r8;
    apply_and_check(0, 0, "R8 zero");
    check("R8 all four show 0", d3 & d2 & d1 & d0, 7'b1000000);
  endtask

  task automatic t_example_r4;
    apply_and_check(3, 2, "R4 3+2");
    check("R4 sum glyph 5", d2, 7'b0010010);
    check("R5 carry glyph 0", d3, 7'b1000000);
  endtask

  task automatic t_max_r3;
    apply_and_check(15, 15, "R3 F+F");
    check("R3 low nibble E", d2, 7'b0000110);
    check("R3 carry 1", d3, 7'b1111001);
  endtask

  task automatic t_carry_edge_r5;
    apply_and_check(8, 8, "R5 8+8");
    check("R5 8+8 low 0", d2, 7'b1000000);
    apply_and_check(15, 0, "R5 F+0");
    check("R5 F+0 no carry", d3, 7'b1000000);
    apply_and_check(15, 1, "R5 F+1");
    check("R5 F+1 carry", d3, 7'b1111001);
  endtask

  task automatic t_letters_r7;
    for (int v = 10; v < 16; v++) begin
      apply_and_check(v, 0, "R7 letter");
      check("R7 letter on sum digit", d2, glyph(v));
    end
    apply_and_check(0, 11, "R7 b");
    check("R7 lowercase b", d1, 7'b0000011);
    apply_and_check(13, 0, "R7 d");
    check("R7 lowercase d", d0, 7'b0100001);
  endtask

  task automatic t_digits_r6;
    apply_and_check(1, 7, "R6 1/7");
    check("R6 glyph 1", d0, 7'b1111001);
    check("R6 glyph 8 sum", d2, 7'b0000000);
  endtask

  task automatic t_no_memory_r9;
    apply_and_check(15, 15, "R9 pre");
    apply_and_check(0, 0, "R9 back to zero");
    apply_and_check(6, 9, "R9 jump");
    apply_and_check(6, 9, "R9 repeat");
  endtask

  task automatic t_sweep;
    for (int b = 0; b < 16; b++)
      for (int a = 0; a < 16; a++)
        apply_and_check(a, b, "R3 sweep");
  endtask

  initial begin
    sw = 8'h00;
    repeat (2) @(posedge clk);
    t_zero_r8();
    t_example_r4();
    t_max_r3();
    t_carry_edge_r5();
    t_letters_r7();
    t_digits_r6();
    t_no_memory_r9();
    t_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule